// File: doc/BRIEF.md
# Resonator loss watchdog

This block decides whether a squared resonator signal is still oscillating. It samples the resonator level on a slow periodic housekeeping tick (around 1.2 kHz, one sample every 0.8 ms or so). It does not measure the resonator's frequency. It only asks whether the level seen at this tick differs from the level seen at the previous tick.

While changes keep arriving, an oscillator-good indicator stays high. When a programmable number of consecutive samples show no change, the block issues a one-cycle request to clear the clock's run flag and drops the indicator. If the clock was showing time at that moment, it also issues a one-cycle request to force the mode machine into its error mode.

The block never restores the run flag or leaves the error mode by itself. That is left to an external command. The resonator input is asynchronous and passes through a two-flop synchroniser before it is sampled.

Top module: `res_loss_wd`

## Requirements
- R1: `res_i` reaches the sampler only through two flops clocked by `clk_i`. A change applied just before an edge is not seen by a tick at that edge or at the following edge. It is seen by a tick two or more edges later.
- R2: At a tick whose synchronised level differs from the level held at the previous tick, `osc_ok_o` is 1 from the next cycle on.
- R3: Every observed level change reloads the idle count, so a timeout needs `limit_i` consecutive unchanged ticks counted after the last change.
- R4: On the `limit_i`-th consecutive unchanged tick, `run_clr_o` is 1 for exactly the one cycle after that tick.
- R5: `force_err_o` pulses together with `run_clr_o` only if `mode_i` equals the time-display code TIME_CODE (default 0) at the expiring tick. In every other mode it stays 0.
- R6: `osc_ok_o` falls to 0 in the same cycle in which `run_clr_o` pulses.
- R7: After a timeout, further unchanged ticks produce no new pulse, and `osc_ok_o` stays 0 until a level change is seen.
- R8: A `limit_i` of 0 disables the timeout: no unchanged sample run ever produces `run_clr_o`.
- R9: While `rst_ni` is low, all outputs are 0, and the held previous level and the idle count are 0.
- R10: In cycles with `tick_i` low, no output and no sampling state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| res_i | input | 1 | Squared resonator level, asynchronous |
| tick_i | input | 1 | Housekeeping sample strobe, one cycle wide |
| mode_i | input | MODE_W | Current clock mode code |
| limit_i | input | CNT_W | Unchanged samples before timeout; 0 disables |
| osc_ok_o | output | 1 | Oscillation observed recently |
| run_clr_o | output | 1 | One-cycle request to clear the run flag |
| force_err_o | output | 1 | One-cycle request to enter the error mode |

## Verification
The bench builds the block with CNT_W = 8, MODE_W = 3 and TIME_CODE = 0. It drives `limit_i` with small values from 0 to 5, so many complete timeouts, reload races and disabled stretches fit into a few thousand cycles. Ticks are one cycle in four and toggles on the input are sparse. This places level changes at every distance from a tick, including inside the two-cycle synchroniser window. Mode codes are drawn across all eight values, so timeouts land both in and out of the time-display mode.

// File: rtl/res_wd_pkg.sv
package res_wd_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned DEF_CNT_W   = 8;
  localparam int unsigned DEF_MODE_W  = 3;

  typedef struct packed {
    logic chg;   // tick with level change
    logic hold;  // tick without level change
  } smp_evt_t;
endpackage

// File: rtl/res_wd_sync.sv
module res_wd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/res_wd_sampler.sv
module res_wd_sampler
  import res_wd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     lvl_i,
  output smp_evt_t evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= 1'b0;
    else if (tick_i) prev_q <= lvl_i;
  end

  assign evt_o.chg  = tick_i & (lvl_i ^ prev_q);
  assign evt_o.hold = tick_i & ~(lvl_i ^ prev_q);
endmodule

// File: rtl/res_wd_idle_timer.sv
module res_wd_idle_timer
  import res_wd_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  smp_evt_t         evt_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] idle_q;
  logic [CNT_W-1:0] lim_m1;

  assign lim_m1   = limit_i - CNT_W'(1);
  // fires once on the transition into the limit; limit 0 never matches
  assign expire_o = evt_i.hold && (limit_i != '0) && (idle_q == lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         idle_q <= '0;
    else if (evt_i.chg)                  idle_q <= '0;
    else if (evt_i.hold && idle_q < limit_i) idle_q <= idle_q + CNT_W'(1);
  end
endmodule

// File: rtl/res_loss_wd.sv
module res_loss_wd
  import res_wd_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned MODE_W = DEF_MODE_W,
  parameter logic [MODE_W-1:0] TIME_CODE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_i,
  input  logic              tick_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CNT_W-1:0]  limit_i,
  output logic              osc_ok_o,
  output logic              run_clr_o,
  output logic              force_err_o
);
  logic     lvl_s;
  smp_evt_t evt;
  logic     expire;
  logic     ok_q, clr_q, ferr_q;

  res_wd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (res_i),
    .q_o   (lvl_s)
  );

  res_wd_sampler u_smp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .lvl_i (lvl_s),
    .evt_o (evt)
  );

  res_wd_idle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .limit_i (limit_i),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q   <= 1'b0;
      clr_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      clr_q  <= expire;
      ferr_q <= expire && (mode_i == TIME_CODE);
      if (evt.chg)     ok_q <= 1'b1;
      else if (expire) ok_q <= 1'b0;
    end
  end

  assign osc_ok_o    = ok_q;
  assign run_clr_o   = clr_q;
  assign force_err_o = ferr_q;
endmodule

// File: rtl/res_loss_wd_chk.sv
module res_loss_wd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic osc_ok_o,
  input logic run_clr_o,
  input logic force_err_o
);
  // R4
  clr_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_clr_o |-> $past(tick_i));
  // R4
  clr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_clr_o |=> !run_clr_o);
  // R5
  ferr_with_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_err_o |-> run_clr_o);
  // R6
  ok_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_clr_o |-> !osc_ok_o);
  // R2
  ok_rise_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_ok_o) |-> $past(tick_i));
  // R10
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> ($stable(osc_ok_o) && !run_clr_o && !force_err_o));
  // R9
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!osc_ok_o && !run_clr_o && !force_err_o));
endmodule

bind res_loss_wd res_loss_wd_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .osc_ok_o   (osc_ok_o),
  .run_clr_o  (run_clr_o),
  .force_err_o(force_err_o)
);

// File: tb/res_loss_wd_test.sv
module res_loss_wd_test;
  localparam int CW = 8;
  localparam int MW = 3;

  logic clk = 1'b0, rst_n = 1'b0, res = 1'b0, tick = 1'b0;
  logic [MW-1:0] mode = '0;
  logic [CW-1:0] lim = 8'd3;
  logic osc_ok, run_clr, force_err;

  int checks = 0, errors = 0;
  string tag = "R9";
  bit done = 0;

  // model state
  logic m_s1 = 0, m_s2 = 0, m_prev = 0, m_ok = 0, m_rc = 0, m_fe = 0;
  int m_idle = 0;

  res_loss_wd #(.CNT_W(CW), .MODE_W(MW), .TIME_CODE(3'd0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .res_i(res), .tick_i(tick), .mode_i(mode),
    .limit_i(lim), .osc_ok_o(osc_ok), .run_clr_o(run_clr), .force_err_o(force_err)
  );

  always #2 clk = ~clk;

  function automatic bit exp_fire(int idle, int l, bit chg);
    return !chg && l != 0 && idle == l - 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_ok = 0; m_rc = 0; m_fe = 0; m_idle = 0;
    end else begin
      if (tick) begin
        bit chg, ex;
        chg = (m_s2 != m_prev);
        ex  = exp_fire(m_idle, int'(lim), chg);
        m_prev = m_s2;
        if (chg) m_idle = 0;
        else if (m_idle < int'(lim)) m_idle++;
        m_rc = ex;
        m_fe = ex && (mode == 3'd0);
        if (chg) m_ok = 1;
        else if (ex) m_ok = 0;
      end else begin
        m_rc = 0; m_fe = 0;
      end
      m_s2 = m_s1; m_s1 = res;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      checks++;
      if (osc_ok !== m_ok || run_clr !== m_rc || force_err !== m_fe) begin
        errors++;
        $display("FAIL %s ok/clr/ferr act=%b%b%b exp=%b%b%b at %0t",
                 tag, osc_ok, run_clr, force_err, m_ok, m_rc, m_fe, $time);
      end
    end
  end

  task automatic step(input bit r, input bit t);
    @(negedge clk);
    res = r; tick = t;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(res, 1'b1);
      for (int j = 0; j < gap; j++) step(res, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0411));
    repeat (3) @(posedge clk);
    #1;
    checks++; // R9 reset state
    if (osc_ok !== 0 || run_clr !== 0 || force_err !== 0) begin
      errors++;
      $display("FAIL R9 reset outputs act=%b%b%b exp=000", osc_ok, run_clr, force_err);
    end
    @(negedge clk); rst_n = 1'b1;

    tag = "R1"; // toggle then tick at once: not yet visible
    step(1'b1, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b0);
    tag = "R2"; // visible now
    step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    tag = "R10";
    repeat (6) step(1'b0, 1'b0);
    tag = "R3"; lim = 8'd3; mode = 3'd2;
    ticks(2, 2);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
    ticks(2, 2);
    tag = "R4"; ticks(2, 1);
    tag = "R6"; ticks(1, 1);
    tag = "R7"; ticks(5, 1);
    tag = "R5"; mode = 3'd0;
    step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    ticks(4, 1);
    tag = "R8"; lim = 8'd0;
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
    ticks(12, 1);

    tag = "R3";
    for (int c = 0; c < 4000; c++) begin
      if (($urandom % 64) == 0) lim = CW'($urandom % 6);
      if (($urandom % 16) == 0) mode = MW'($urandom);
      if (($urandom % 12) == 0) tag = "R5";
      step((($urandom % 20) == 0) ? ~res : res, ($urandom % 4) == 0);
    end
    step(res, 1'b0); step(res, 1'b0);
    done = 1;
    #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule